// File: doc/BRIEF.md
# Graphics Memory Contention Wait Generator

This block sits between a CPU bus and an on-chip graphics memory that the display scan-out also reads. There is only one copy of the picture, so the CPU cannot be allowed to touch the memory while the display is fetching from it. The block decides whether a CPU memory cycle falls into the paged-in graphics window or into the character-generator rewrite window. When a graphics access meets an active display fetch, it pulls the active-low wait line. The access then completes in the first free slot.

A single I/O page register holds the two window enables. Reading the same register returns the character-generator enable together with the horizontal and vertical blanking flags. Software can poll these flags and place its graphics bursts inside blanking, where no stall happens. Video timing comes in as inputs: the two blanking levels, which may be asynchronous, and a fetch-active strobe in the block's own clock domain.

Top module: `gfxContentionWait`

## Requirements
- R1: After reset the page register is 0x00. A read of I/O port 0xFD with both blanking inputs low returns 0x00, and no memory access causes a wait.
- R2: While page bit 0 is set, a memory request with address bits [15:14] equal to 2'b11 (0xC000–0xFFFF) raises `gramSel`, unless R3 claims that address.
- R3: While page bit 7 is set, a memory request with address bits [15:12] equal to 4'hD (0xD000–0xDFFF) raises `cgSel` and not `gramSel`. This holds even when bit 0 is also set. A character-generator access never waits.
- R4: A read of port 0xFD (address bits [7:0]) returns page bit 7 in bit 7, V-blank in bit 6 and H-blank in bit 5, with bits 4..0 at zero. `rdData` is zero when the port is not being read.
- R5: Each blanking input passes through two flip-flops. A change shows in the readback after the second rising clock edge and not after the first.
- R6: `waitN` is low in every cycle in which `gramSel` is high, `fetchActive` is high and the request has not yet completed. The stall therefore never outlasts the fetch strobe.
- R7: `waitN` is released in the first cycle in which `fetchActive` is low. `accessGo` pulses in that same cycle, exactly once per held request. After completion, a new fetch does not stall the finished request.
- R8: A request outside both windows, or inside a window whose page bit is clear, never drives `waitN` low and never raises `gramSel` or `accessGo`.
- R9: An I/O write to any port other than 0xFD leaves the page register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rstN | input | 1 | Synchronous active-low reset |
| addr | input | 16 | CPU address; bits [7:0] select the I/O port |
| wrData | input | 8 | CPU write data for I/O writes |
| ioWr | input | 1 | I/O write strobe, one cycle per write |
| ioRd | input | 1 | I/O read cycle active |
| memReq | input | 1 | Memory request, held until the access completes |
| fetchActive | input | 1 | Display fetch owns the graphics memory |
| hblankIn | input | 1 | Horizontal blanking, asynchronous |
| vblankIn | input | 1 | Vertical blanking, asynchronous |
| waitN | output | 1 | Active-low wait to the CPU |
| gramSel | output | 1 | Request targets the enabled graphics window |
| cgSel | output | 1 | Request targets the enabled character-generator window |
| accessGo | output | 1 | Graphics access is performed in this cycle |
| rdData | output | 8 | I/O read data |

## Verification
Two things can happen in the same cycle. The display fetch can end in the same cycle that a held graphics request is waiting, so the wait release and the access pulse must land together and only once. The bench holds a request across a fetch, drops the fetch and checks the released wait and the single `accessGo` at that negative edge. It then checks that `accessGo` stays quiet in the next cycle and during a later fetch. Separately, a page-register read is placed on the cycles either side of a blanking edge reaching the second synchroniser stage. The old value must be returned before that point and the new value after it.

// File: rtl/gfx_wait_pkg.sv
package gfx_wait_pkg;
  localparam int GRAM_EN_BIT = 0;
  localparam int CG_EN_BIT   = 7;
  localparam int VB_BIT      = 6;
  localparam int HB_BIT      = 5;

  typedef struct packed {
    logic pageWr;
    logic pageRd;
  } vwStrobes_t;
endpackage

// File: rtl/gfx_wait_sync.sv
module gfx_wait_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) stage[s] <= '0;
          else       stage[s] <= stage[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/gfx_wait_datapath.sv
module gfx_wait_datapath
  import gfx_wait_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  vwStrobes_t        strobes,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hblankIn,
  input  logic              vblankIn,
  output logic              gramEn,
  output logic              cgEn,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] pageReg;
  logic [1:0]        blankSync;

  always_ff @(posedge clk) begin
    if (!rstN)               pageReg <= '0;
    else if (strobes.pageWr) pageReg <= wrData;
  end

  gfx_wait_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn({vblankIn, hblankIn}),
    .syncOut(blankSync)
  );

  assign gramEn = pageReg[GRAM_EN_BIT];
  assign cgEn   = pageReg[CG_EN_BIT];

  always_comb begin
    rdData = '0;
    if (strobes.pageRd) begin
      rdData[CG_EN_BIT] = cgEn;
      rdData[VB_BIT]    = blankSync[1];
      rdData[HB_BIT]    = blankSync[0];
    end
  end

  // R9: without a write strobe the page register holds its value
  p_page_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.pageWr |=> $stable(pageReg));

  // R2/R3: a write lands in the enables on the next cycle
  p_page_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pageWr |=> (cgEn == $past(wrData[CG_EN_BIT])) &&
                       (gramEn == $past(wrData[GRAM_EN_BIT])));
endmodule

// File: rtl/gfx_wait_control.sv
module gfx_wait_control
  import gfx_wait_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [7:0]  PAGE_PORT = 8'hFD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic              memReq,
  input  logic              fetchActive,
  input  logic              gramEn,
  input  logic              cgEn,
  output vwStrobes_t        strobes,
  output logic              waitN,
  output logic              gramSel,
  output logic              cgSel,
  output logic              accessGo
);
  logic portHit;
  logic inGramWin;
  logic inCgWin;
  logic doneFlag;

  assign portHit   = (addr[7:0] == PAGE_PORT);
  assign inGramWin = (addr[ADDR_W-1 -: 2] == 2'b11);
  assign inCgWin   = (addr[ADDR_W-1 -: 4] == 4'hD);

  always_comb begin
    strobes.pageWr = ioWr & portHit;
    strobes.pageRd = ioRd & portHit;
  end

  assign cgSel    = memReq & cgEn & inCgWin;
  assign gramSel  = memReq & gramEn & inGramWin & ~cgSel;
  assign waitN    = ~(gramSel & fetchActive & ~doneFlag);
  assign accessGo = gramSel & ~fetchActive & ~doneFlag;

  always_ff @(posedge clk) begin
    if (!rstN)         doneFlag <= 1'b0;
    else if (!memReq)  doneFlag <= 1'b0;
    else if (accessGo) doneFlag <= 1'b1;
  end

  // R7: the access slot is never granted while the fetch owns memory
  p_go_outside_fetch_r7: assert property (@(posedge clk) disable iff (!rstN)
    accessGo |-> !fetchActive && waitN);

  // R7: one slot per held request
  p_single_go_r7: assert property (@(posedge clk) disable iff (!rstN)
    accessGo && memReq |=> !accessGo);

  // R8: addresses below the graphics window never stall
  p_no_wait_outside_r8: assert property (@(posedge clk) disable iff (!rstN)
    (addr[ADDR_W-1 -: 2] != 2'b11) |-> waitN && !gramSel);

  // R6: the stall never outlives the fetch strobe
  p_wait_bounded_r6: assert property (@(posedge clk) disable iff (!rstN)
    !waitN |-> fetchActive);

  // R3: the two windows are never selected together
  p_window_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({gramSel, cgSel}));
endmodule

// File: rtl/gfxContentionWait.sv
module gfxContentionWait
  import gfx_wait_pkg::*;
#(
  parameter int         ADDR_W      = 16,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [7:0] PAGE_PORT   = 8'hFD
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              ioWr,
  input  logic              ioRd,
  input  logic              memReq,
  input  logic              fetchActive,
  input  logic              hblankIn,
  input  logic              vblankIn,
  output logic              waitN,
  output logic              gramSel,
  output logic              cgSel,
  output logic              accessGo,
  output logic [DATA_W-1:0] rdData
);
  vwStrobes_t strobes;
  logic       gramEn;
  logic       cgEn;

  gfx_wait_control #(.ADDR_W(ADDR_W), .PAGE_PORT(PAGE_PORT)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .addr       (addr),
    .ioWr       (ioWr),
    .ioRd       (ioRd),
    .memReq     (memReq),
    .fetchActive(fetchActive),
    .gramEn     (gramEn),
    .cgEn       (cgEn),
    .strobes    (strobes),
    .waitN      (waitN),
    .gramSel    (gramSel),
    .cgSel      (cgSel),
    .accessGo   (accessGo)
  );

  gfx_wait_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrData  (wrData),
    .hblankIn(hblankIn),
    .vblankIn(vblankIn),
    .gramEn  (gramEn),
    .cgEn    (cgEn),
    .rdData  (rdData)
  );
endmodule

// File: tb/test_gfxContentionWait.sv
module test_gfxContentionWait;
  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] addr;
  logic [7:0]  wrData;
  logic        ioWr, ioRd, memReq, fetchActive, hblankIn, vblankIn;
  logic        waitN, gramSel, cgSel, accessGo;
  logic [7:0]  rdData;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  gfxContentionWait i_gfxContentionWait (
    .clk(clk), .rstN(rstN), .addr(addr), .wrData(wrData), .ioWr(ioWr),
    .ioRd(ioRd), .memReq(memReq), .fetchActive(fetchActive),
    .hblankIn(hblankIn), .vblankIn(vblankIn), .waitN(waitN),
    .gramSel(gramSel), .cgSel(cgSel), .accessGo(accessGo), .rdData(rdData)
  );

  // {page[7:0], addr[15:0], fetch, expWaitN, expGram, expCg, expGo}
  localparam int NV = 10;
  localparam logic [28:0] VEC [NV] = '{
    {8'h00, 16'hC000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R8 page bit clear
    {8'h01, 16'hC000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R6 stall
    {8'h01, 16'hC000, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},  // R7 free slot
    {8'h01, 16'hBFFF, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R8 below window
    {8'h01, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 top of window
    {8'h80, 16'hD123, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R3 CG window
    {8'h81, 16'hD800, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},  // R3 CG priority
    {8'h81, 16'hE000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},  // R2 outside CG
    {8'h80, 16'hC000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},  // R8 graphics off
    {8'h80, 16'hCFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}   // R8 graphics off
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic writePort(input logic [7:0] port, input logic [7:0] v);
    @(negedge clk);
    addr = {8'h00, port}; wrData = v; ioWr = 1'b1;
    @(negedge clk);
    ioWr = 1'b0;
  endtask

  task automatic readPort(input logic [7:0] port, output logic [7:0] v);
    @(negedge clk);
    addr = {8'h00, port}; ioRd = 1'b1;
    #1 v = rdData;
    ioRd = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    rstN = 1'b0; addr = '0; wrData = '0; ioWr = 0; ioRd = 0; memReq = 0;
    fetchActive = 0; hblankIn = 0; vblankIn = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    readPort(8'hFD, rv);
    check("R1 reset readback", rv, 8'h00);
    @(negedge clk);
    addr = 16'hC000; memReq = 1; fetchActive = 1;
    #1 check("R1 no wait after reset", {7'd0, waitN}, 8'h01);
    memReq = 0; fetchActive = 0;

    // vector table
    foreach (VEC[i]) begin
      logic [28:0] v;
      v = VEC[i];
      writePort(8'hFD, v[28:21]);
      @(negedge clk);
      addr = v[20:5]; fetchActive = v[4]; memReq = 1;
      #1;
      check($sformatf("R6/R7/R8 vec%0d waitN", i), {7'd0, waitN}, {7'd0, v[3]});
      check($sformatf("R2/R3 vec%0d gramSel", i), {7'd0, gramSel}, {7'd0, v[2]});
      check($sformatf("R3 vec%0d cgSel", i), {7'd0, cgSel}, {7'd0, v[1]});
      check($sformatf("R7 vec%0d accessGo", i), {7'd0, accessGo}, {7'd0, v[0]});
      @(negedge clk);
      memReq = 0; fetchActive = 0;
    end

    // R4 readback fields and idle data
    writePort(8'hFD, 8'hFF);
    readPort(8'hFD, rv);
    check("R4 readback with blanks low", rv, 8'h80);
    readPort(8'hFC, rv);
    check("R4 other port reads zero", rv, 8'h00);

    // R9 write to another port
    writePort(8'hFC, 8'h00);
    readPort(8'hFD, rv);
    check("R9 page kept after foreign write", rv, 8'h80);

    // R5 synchroniser latency, R4 bit positions
    @(negedge clk);
    hblankIn = 1;
    @(negedge clk);
    addr = 16'h00FD; ioRd = 1;
    #1 check("R5 hblank after one edge", rdData, 8'h80);
    @(negedge clk);
    #1 check("R5 hblank after two edges", rdData, 8'hA0);
    ioRd = 0;
    vblankIn = 1; hblankIn = 0;
    repeat (2) @(negedge clk);
    readPort(8'hFD, rv);
    check("R4 vblank in bit 6", rv, 8'hC0);
    vblankIn = 0;
    writePort(8'hFD, 8'h01);

    // R6/R7 held request across a fetch
    @(negedge clk);
    addr = 16'hC400; memReq = 1; fetchActive = 1;
    #1 check("R6 stall cycle 1", {7'd0, waitN}, 8'h00);
    @(negedge clk);
    #1 check("R6 stall cycle 2", {7'd0, waitN}, 8'h00);
    check("R7 no go during fetch", {7'd0, accessGo}, 8'h00);
    @(negedge clk);
    fetchActive = 0;
    #1 check("R7 wait released", {7'd0, waitN}, 8'h01);
    check("R7 go in free slot", {7'd0, accessGo}, 8'h01);
    @(negedge clk);
    #1 check("R7 go only once", {7'd0, accessGo}, 8'h00);
    fetchActive = 1;
    #1 check("R7 finished request not stalled", {7'd0, waitN}, 8'h01);
    @(negedge clk);
    memReq = 0; fetchActive = 0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule